// File: doc/BRIEF.md
# Static memory bus controller

This block sits between a simple synchronous host port and a group of external asynchronous parallel memories, such as SRAM or NOR-style flash. Every bank shares one external address bus and one data bus. Each bank has its own active-low chip select and its own timing word. The word sets the bank's data width (8 or 16 bits), its byte order, the wait states in the strobe phase, the delay from chip select to strobe, and the idle turnaround cycles after an access.

The host raises `h_req` for one cycle while `h_busy` is low. With it the host gives a halfword address, whose top bits select the bank, a direction and a burst length. The controller then runs the beats one after another. It keeps the chip select low for the whole burst and adds turnaround only after the last beat. On a 16-bit bank each beat is one external access. On an 8-bit bank each beat is two byte accesses at consecutive byte addresses. The controller runs only one external access at a time. An external wait input, passed through two synchroniser flops, stretches the strobe phase.

`h_rdy` pulses once per beat and carries the assembled read data. For a write burst, the host places the next halfword on `h_wdata` during that `h_rdy` cycle.

Top module: `statmem_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every chip select, `mem_oe_n` and `mem_we_n` are high, and `mem_dq_oe`, `h_busy` and `h_rdy` are low.
- R2: At most one chip select is low in any cycle. The read and write strobes are never low together, and a strobe is low only while a chip select is low.
- R3: The strobe of the first access of a transaction goes low exactly D cycles after the chip select falls, where D is bank config bits [14:11]. Each later access of the same transaction begins with one cycle with strobes high, followed by D further cycles.
- R4: With the wait input low, each strobe phase lasts exactly W+1 cycles, where W is bank config bits [6:2] (0 to 31).
- R5: The strobe phase ends only after W cycles have elapsed and the wait input, delayed by two synchroniser flops, is low. If wait rises with the strobe and stays high for H cycles, and 2 <= W <= H+1, the phase lasts H+3 cycles.
- R6: After the last strobe of a transaction, the chip selects stay high and `h_busy` stays high for exactly T cycles, where T is bank config bits [10:7]. Only then is a new request accepted.
- R7: A bank with config bit 0 set is 16 bits wide. Each beat is one access at `mem_a` = halfword offset. Config bit 1 = 0 passes the halfword straight through. Config bit 1 = 1 swaps its two bytes in both directions.
- R8: A bank with config bit 0 clear is 8 bits wide and uses lanes [7:0]. Each beat becomes accesses at `mem_a` = 2*offset and then 2*offset+1. With config bit 1 = 0 the first access carries host bits [7:0]; with bit 1 = 1 it carries host bits [15:8]. Read data is assembled in the same order.
- R9: A request with `h_len` = N runs N+1 beats at consecutive halfword offsets. The chip select falls once for the whole burst, and write data for beat k+1 is taken at the end of the `h_rdy` cycle of beat k.
- R10: `h_addr` bits [AW-1:AW-BW] select the bank whose chip select is driven and whose config word times the access. The remaining bits are the offset within the bank.
- R11: `h_rdy` is high for exactly one cycle per beat, never two cycles in a row, and `h_rdata` holds the beat's full read data in that cycle.
- R12: `mem_dq_oe` is high only during an active write access. `mem_dq_o` carries the write data placed per R7/R8 throughout the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | One-cycle request, accepted while `h_busy` is low |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Halfword address; top BW bits select the bank |
| h_len | input | LW | Burst beats minus one |
| h_wdata | input | 16 | Write halfword for the current beat |
| h_busy | output | 1 | Transaction or turnaround in progress |
| h_rdy | output | 1 | Beat complete pulse |
| h_rdata | output | 16 | Read halfword, valid with `h_rdy` |
| cfg | input | NB*15 | Per-bank config words, bank k at bits [15k+14:15k] |
| mem_cs_n | output | NB | Per-bank chip selects, active low |
| mem_a | output | AW-BW+1 | Shared external address |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data returned by memory |
| mem_wait | input | 1 | Asynchronous wait from the device, active high |

## Verification
Most faults in the sequencing counters or state register show up within one access. They appear as a strobe that starts one cycle early or late, a strobe phase whose length is not W+1 (or H+3 under wait), or a turnaround count that differs from T. A wrong byte-order select or piece index shows up as a byte in the wrong lane or at the wrong odd/even address, on the very first 8-bit write. A wrong beat or offset counter shows up at the end of the burst as an extra or missing `h_rdy`, or as a second chip-select fall.

// File: rtl/statmem_ctrl.sv
module statmem_ctrl #(
  parameter int NB = 4,
  parameter int AW = 12,
  parameter int LW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      h_req,
  input  logic                      h_we,
  input  logic [AW-1:0]             h_addr,
  input  logic [LW-1:0]             h_len,
  input  logic [15:0]               h_wdata,
  output logic                      h_busy,
  output logic                      h_rdy,
  output logic [15:0]               h_rdata,
  input  logic [NB*15-1:0]          cfg,
  output logic [NB-1:0]             mem_cs_n,
  output logic [AW-((NB>1)?$clog2(NB):1):0] mem_a,
  output logic                      mem_oe_n,
  output logic                      mem_we_n,
  output logic [15:0]               mem_dq_o,
  output logic                      mem_dq_oe,
  input  logic [15:0]               mem_dq_i,
  input  logic                      mem_wait
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam int OW = AW - BW;
  localparam int CW = 15;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_GAP, S_TURN} st_t;

  st_t            st;
  logic [BW-1:0]  bank;
  logic [OW-1:0]  off;
  logic           wr, piece, rdy;
  logic [LW-1:0]  left;
  logic [4:0]     cnt;
  logic [15:0]    wbuf, rbuf;
  logic [CW-1:0]  cc;
  logic [1:0]     wsync;

  function automatic logic [15:0] bswap(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  wire [CW-1:0] ncfg   = cfg[CW*int'(h_addr[AW-1 -: BW]) +: CW];
  wire          c_wide = cc[0];
  wire          c_big  = cc[1];
  wire [4:0]    c_wait = cc[6:2];
  wire [3:0]    c_turn = cc[10:7];
  wire [3:0]    c_dly  = cc[14:11];
  wire          ws     = wsync[1];
  wire          hold   = (cnt < c_wait) || ws;
  wire          last   = c_wide || piece;
  wire          hi     = c_big ^ piece;
  wire          act    = (st == S_SETUP) || (st == S_STRB) || (st == S_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bank <= '0; off <= '0; wr <= 1'b0; piece <= 1'b0;
      rdy <= 1'b0; left <= '0; cnt <= '0; wbuf <= '0; rbuf <= '0;
      cc <= '0; wsync <= '0;
    end else begin
      wsync <= {wsync[0], mem_wait};
      rdy   <= 1'b0;
      case (st)
        S_IDLE: if (h_req) begin
          bank  <= h_addr[AW-1 -: BW];
          off   <= h_addr[OW-1:0];
          wr    <= h_we;
          left  <= h_len;
          wbuf  <= h_wdata;
          cc    <= ncfg;
          piece <= 1'b0;
          cnt   <= '0;
          st    <= (ncfg[14:11] == 4'd0) ? S_STRB : S_SETUP;
        end
        S_SETUP: begin
          if (cnt == 5'(c_dly) - 5'd1) begin
            cnt <= '0;
            st  <= S_STRB;
          end else cnt <= cnt + 5'd1;
        end
        S_STRB: begin
          if (!hold) begin
            cnt <= '0;
            if (!wr) begin
              if (c_wide)  rbuf       <= c_big ? bswap(mem_dq_i) : mem_dq_i;
              else if (hi) rbuf[15:8] <= mem_dq_i[7:0];
              else         rbuf[7:0]  <= mem_dq_i[7:0];
            end
            if (last) begin
              rdy   <= 1'b1;
              piece <= 1'b0;
              if (left == '0) st <= (c_turn == 4'd0) ? S_IDLE : S_TURN;
              else begin
                left <= left - 1'b1;
                off  <= off + 1'b1;
                st   <= S_GAP;
              end
            end else begin
              piece <= 1'b1;
              st    <= S_GAP;
            end
          end else if (cnt != 5'd31) cnt <= cnt + 5'd1;
        end
        S_GAP: begin
          if (!piece) wbuf <= h_wdata;
          cnt <= '0;
          st  <= (c_dly == 4'd0) ? S_STRB : S_SETUP;
        end
        S_TURN: begin
          if (cnt == 5'(c_turn) - 5'd1) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else cnt <= cnt + 5'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_cs
    assign mem_cs_n[g] = !(act && (bank == BW'(g)));
  end

  wire [7:0] byte_o = hi ? wbuf[15:8] : wbuf[7:0];

  assign mem_oe_n  = !((st == S_STRB) && !wr);
  assign mem_we_n  = !((st == S_STRB) && wr);
  assign mem_dq_oe = act && wr;
  assign mem_dq_o  = c_wide ? (c_big ? bswap(wbuf) : wbuf) : {8'h00, byte_o};
  assign mem_a     = c_wide ? {1'b0, off} : {off, piece};
  assign h_busy    = (st != S_IDLE);
  assign h_rdy     = rdy;
  assign h_rdata   = rbuf;
endmodule

module statmem_ctrl_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic          mem_wait,
  input logic          h_rdy,
  input logic          h_busy
);
  logic strb;
  assign strb = !mem_oe_n || !mem_we_n;

  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r2_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> !(&mem_cs_n));
  a_r12_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  a_r12_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (&mem_cs_n) |-> !mem_dq_oe);
  a_r11_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    h_rdy |=> !h_rdy);
  a_r5_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && $past(mem_wait, 2)) |=> strb);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !h_busy |-> ((&mem_cs_n) && mem_oe_n && mem_we_n));
endmodule

bind statmem_ctrl statmem_ctrl_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_wait(mem_wait),
  .h_rdy(h_rdy), .h_busy(h_busy)
);

// File: tb/statmem_ctrl_bench.sv
module statmem_ctrl_bench;
  localparam int NB = 4, AW = 12, LW = 4, EAW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_req = 1'b0, h_we = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [LW-1:0] h_len = '0;
  logic [15:0] h_wdata = '0;
  logic h_busy, h_rdy;
  logic [15:0] h_rdata;
  logic [NB*15-1:0] cfg = '0;
  logic [NB-1:0] mem_cs_n;
  logic [EAW-1:0] mem_a;
  logic mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic mem_wait = 1'b0;

  statmem_ctrl #(.NB(NB), .AW(AW), .LW(LW)) u_statmem_ctrl (.*);

  always #5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  int hw = 0;
  logic [15:0] w [0:15];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // memory model and monitor
  logic [15:0] mdl [0:NB-1][0:2047];
  int pc_pre [0:1023], pc_len [0:1023], pc_a [0:1023], pc_bk [0:1023];
  logic [15:0] pc_dat [0:1023];
  logic pc_oe [0:1023];
  int n = 0, q = 0, tcnt = 0, falls = 0, rcnt = 0, bad = 0, multi = 0, wc = 0;
  logic pstrb = 1'b0, pcs = 1'b0;

  function automatic int csidx();
    for (int k = 0; k < NB; k++) if (!mem_cs_n[k]) return k;
    return 0;
  endfunction

  always_comb begin
    mem_dq_i = 16'h0000;
    for (int k = 0; k < NB; k++) if (!mem_cs_n[k]) mem_dq_i = mdl[k][mem_a];
  end

  always @(negedge clk) begin
    logic strb, anycs;
    strb  = !mem_oe_n || !mem_we_n;
    anycs = !(&mem_cs_n);
    if (!rst_n) begin
      for (int k = 0; k < NB; k++)
        for (int a = 0; a < 2048; a++)
          mdl[k][a] = 16'(k * 16'h1357 + a * 16'h0301 + 16'h00a5);
    end else begin
      if ($countones(~mem_cs_n) > 1) multi++;
      if (!anycs && mem_dq_oe) bad++;
      if (anycs && !pcs) falls++;
      if (h_rdy) rcnt++;
      if (h_busy && !anycs && !strb) tcnt++;
      if (!mem_we_n) begin
        if (cfg[csidx()*15]) mdl[csidx()][mem_a] = mem_dq_o;
        else mdl[csidx()][mem_a] = {8'h00, mem_dq_o[7:0]};
      end
      if (wc > 0) begin
        wc--;
        if (wc == 0) mem_wait = 1'b0;
      end
      if (strb && !pstrb) begin
        pc_pre[n%1024] = q; pc_len[n%1024] = 0;
        pc_a[n%1024] = int'(mem_a); pc_bk[n%1024] = csidx();
        if (hw > 0) begin mem_wait = 1'b1; wc = hw; end
      end
      if (strb) begin
        pc_len[n%1024]++;
        pc_dat[n%1024] = mem_dq_o;
        pc_oe[n%1024] = mem_dq_oe;
      end
      if (!strb && pstrb) n++;
      if (strb) q = 0; else if (anycs) q++;
      pstrb = strb; pcs = anycs;
    end
  end

  function automatic logic [14:0] mkcfg(input bit wide, input bit big, input int W, input int T, input int D);
    return {4'(D), 4'(T), 5'(W), big, wide};
  endfunction

  function automatic logic [15:0] sw(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic run_txn(input int bk, input bit wr, input int off, input int len);
    logic [14:0] c;
    bit wide, big;
    int W, T, D, L, np, n0, t0, f0, r0, b0, m0, beat;
    logic [15:0] er [0:15];
    c = cfg[bk*15 +: 15];
    wide = c[0]; big = c[1]; W = int'(c[6:2]); T = int'(c[10:7]); D = int'(c[14:11]);
    L = (hw == 0 || W < 2 || W > hw + 1) ? W + 1 : hw + 3;
    np = wide ? len + 1 : 2 * (len + 1);
    for (int b = 0; b <= len; b++) begin
      if (wide) er[b] = big ? sw(mdl[bk][off + b]) : mdl[bk][off + b];
      else if (big) er[b] = {mdl[bk][2*(off+b)][7:0], mdl[bk][2*(off+b)+1][7:0]};
      else er[b] = {mdl[bk][2*(off+b)+1][7:0], mdl[bk][2*(off+b)][7:0]};
    end
    n0 = n; t0 = tcnt; f0 = falls; r0 = rcnt; b0 = bad; m0 = multi;
    @(negedge clk);
    h_req = 1'b1; h_we = wr; h_addr = {2'(bk), 10'(off)}; h_len = 4'(len); h_wdata = w[0];
    @(negedge clk);
    h_req = 1'b0;
    beat = 0;
    forever begin
      if (h_rdy) begin
        if (!wr && beat <= len)
          chk(h_rdata == er[beat], "R11 R8 R7 read data", int'(h_rdata), int'(er[beat]));
        beat++;
        if (beat <= 15) h_wdata = w[beat];
      end
      if (!h_busy) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk(rcnt - r0 == len + 1, "R11 R9 ready count", rcnt - r0, len + 1);
    chk(falls - f0 == 1, "R9 chip select falls", falls - f0, 1);
    chk(tcnt - t0 == T, "R6 turnaround", tcnt - t0, T);
    chk(bad - b0 == 0 && multi - m0 == 0, "R12 R2 bus release", bad - b0, 0);
    chk(n - n0 == np, "R8 R7 access count", n - n0, np);
    for (int i = 0; i < np && i < n - n0; i++) begin
      int j, b, p, ea;
      logic [15:0] ed;
      j = (n0 + i) % 1024;
      b = wide ? i : i / 2;
      p = wide ? 0 : i % 2;
      ea = wide ? off + b : 2 * (off + b) + p;
      chk(pc_pre[j] == ((i == 0) ? D : D + 1), "R3 setup cycles", pc_pre[j], (i == 0) ? D : D + 1);
      chk(pc_len[j] == L, "R4 R5 strobe length", pc_len[j], L);
      chk(pc_a[j] == ea && pc_bk[j] == bk, "R10 R9 address/bank", pc_a[j] * 16 + pc_bk[j], ea * 16 + bk);
      if (wr) begin
        if (wide) ed = big ? sw(w[b]) : w[b];
        else ed = {8'h00, (big ^ (p != 0)) ? w[b][15:8] : w[b][7:0]};
        chk(pc_dat[j] == ed && pc_oe[j], "R12 R7 R8 write data", int'(pc_dat[j]), int'(ed));
      end else
        chk(!pc_oe[j], "R12 read no drive", 1, 0);
    end
  endtask

  initial begin
    int dv [0:2], wv [0:2];
    dv = '{0, 2, 15}; wv = '{0, 1, 31};
    repeat (3) @(negedge clk);
    chk(&mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !h_busy && !h_rdy,
        "R1 reset outputs", {28'h0, mem_cs_n}, 15);
    rst_n = 1'b1;
    @(negedge clk);
    chk(&mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !h_busy && !h_rdy && h_rdata == 0,
        "R1 after reset", int'(h_rdata), 0);
    for (int bk = 0; bk < NB; bk++)
      for (int di = 0; di < 3; di++)
        for (int wi = 0; wi < 3; wi++) begin
          int off;
          hw = 0;
          cfg[bk*15 +: 15] = mkcfg(bk < 2, bk % 2 == 1, wv[wi], ((bk + di + wi) % 4) * 5, dv[di]);
          off = bk * 37 + di * 11 + wi * 5;
          for (int b = 0; b < 16; b++) w[b] = 16'((bk * 9 + di * 3 + wi) * 16'h1111 + b * 16'h0203 + 16'h0c41);
          run_txn(bk, 1'b1, off, 2);
          run_txn(bk, 1'b0, off, 2);
        end
    for (int bi = 0; bi < 2; bi++)
      for (int wi = 0; wi < 3; wi++)
        for (int hi = 0; hi < 3; hi++) begin
          int W, H;
          W = (wi == 0) ? 2 : (wi == 1) ? 3 : 5;
          H = (hi == 0) ? 1 : (hi == 1) ? 3 : 6;
          cfg[bi*2*15 +: 15] = mkcfg(bi == 0, 1'b0, W, 1, 1);
          hw = H;
          run_txn(bi * 2, 1'b0, 100 + wi * 3 + hi, 0);
        end
    hw = 0;
    cfg[3*15 +: 15] = mkcfg(1'b0, 1'b1, 0, 0, 0);
    for (int b = 0; b < 16; b++) w[b] = 16'(16'h8001 + b * 16'h1023);
    run_txn(3, 1'b1, 500, 15);
    run_txn(3, 1'b0, 500, 15);
    cfg[1*15 +: 15] = mkcfg(1'b1, 1'b1, 0, 0, 0);
    run_txn(1, 1'b0, 700, 15);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule